// File: doc/BRIEF.md
# Security-Banked Interrupt Control and State Register

This block is one memory-mapped word of a small interrupt controller that serves two security states. A read returns a snapshot of the controller: the number of the exception now running, the number of the best pending exception, a flag that tells whether an exception return would go back to base level, and the pending flags of three system exceptions. A write sets or clears pending state for the periodic timer exception, the software-pendable service exception and the non-maskable interrupt (NMI).

Timer and service pending flags exist twice, once for the secure world and once for the non-secure world. Each access reaches the copy picked by its own secure attribute. NMI pending state is a single flag. A configuration input says whether non-secure software may see and control it, and a build parameter selects the newer architecture, where an extra write bit can clear the NMI. Hardware events pend the timer and the NMI, and acknowledge inputs from the exception entry logic clear them. Prioritisation and vector fetch are left to the blocks around this one, which supply the active vector, the pending vector and the active nesting depth.

Top module: `icsr_banked`

## Requirements
- R1: While rst_n is low, every pending flag, rd_valid and rd_data are 0 at the next clock edge.
- R2: A read (req_valid=1, req_write=0) gives rd_valid=1 exactly one edge later. For a read of the register offset (default 0xD04), rd_data[8:0] holds active_vec and rd_data[20:12] holds pend_vec as sampled in the request cycle. In every cycle without a read, rd_valid and rd_data are 0.
- R3: rd_data[11] is 1 when active_depth in the request cycle is 0 or 1, and 0 when it is 2 or more.
- R4: rd_data[26] reports the timer flag and rd_data[28] the service flag of the bank chosen by req_secure: index 1 (secure) when req_secure=1, index 0 (non-secure) when req_secure=0.
- R5: A write to the register offset with bit 26 set pends the timer, and one with bit 28 set pends the service exception, in the bank chosen by req_secure only. The other bank does not change.
- R6: A write with bit 25 set clears the timer flag, and one with bit 27 set clears the service flag, in the selected bank. When one write both sets and clears the same flag, it ends up set.
- R7: tick_evt[b] pends the timer of bank b, and tick_ack[b] and sv_ack[b] clear the timer and service flags of bank b. Any set in a cycle beats a clear of the same flag in that cycle.
- R8: rd_data[31] is 1 only when the NMI is pending and nmi_ns_en is 1, whatever the access's secure attribute.
- R9: With nmi_ns_en=1, a write with bit 31 set pends the NMI. A write with bit 30 set and bit 31 clear clears it. A write with both bits set leaves the NMI pending. With nmi_ns_en=0, neither bit changes NMI state.
- R10: With NEW_ARCH=0, write bit 30 has no effect on NMI state.
- R11: A read of any other offset returns rd_data=0 with rd_valid=1. A write to any other offset changes no state.
- R12: rd_data bits 30:29, 27, 25:21 and 10:9 always read 0.
- R13: nmi_evt pends the NMI and nmi_ack clears it. An event beats an acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Access comes from the secure state |
| nmi_ns_en | input | 1 | Non-secure software may see and control NMI pending state |
| active_vec | input | VEC_W | Exception number now running, 0 in thread mode |
| pend_vec | input | VEC_W | Best pending exception number, 0 if none |
| active_depth | input | DEPTH_W | Number of exceptions currently active |
| tick_evt | input | 2 | Timer event per bank, index 1 = secure |
| tick_ack | input | 2 | Timer exception taken, per bank |
| sv_ack | input | 2 | Service exception taken, per bank |
| nmi_evt | input | 1 | External NMI request |
| nmi_ack | input | 1 | NMI taken |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| tick_pend | output | 2 | Timer pending flags, index 1 = secure |
| sv_pend | output | 2 | Service pending flags, index 1 = secure |
| nmi_pend | output | 1 | NMI pending |

## Verification
Every state change from a write, event or acknowledge appears on the pending outputs one rising edge after the cycle that carries it. A read issued in the next cycle shows it in rd_data one further edge later, and the read reflects the flags and side inputs of its own request cycle. The bench drives every input on the falling edge and samples every output at the following falling edge, after exactly one rising edge. A reference state in the bench advances at that same edge, so each comparison matches the cycle in which the design must have updated. An exhaustive sweep covers all 64 combinations of the six write-control bits, crossed with bank, the NMI enable, a full or empty starting state and both architecture modes.

// File: rtl/icsr_pkg.sv
// Package: shared field positions and the decoded write command of the
// banked interrupt control register. Assumes a 32-bit data word.
package icsr_pkg;

    localparam int DATA_W       = 32;
    localparam int NBANK        = 2;   // index 1 = secure bank
    localparam int FIELD_W      = 9;   // width of both vector fields

    localparam int BIT_NMI_SET  = 31;
    localparam int BIT_NMI_CLR  = 30;
    localparam int BIT_SV_SET   = 28;
    localparam int BIT_SV_CLR   = 27;
    localparam int BIT_TICK_SET = 26;
    localparam int BIT_TICK_CLR = 25;
    localparam int PVEC_LSB     = 12;
    localparam int BIT_RTB      = 11;
    localparam int AVEC_LSB     = 0;

    // One write, decoded; NMI bits are still ungated by enable and mode
    typedef struct packed {
        logic tick_set;
        logic tick_clr;
        logic sv_set;
        logic sv_clr;
        logic nmi_set;
        logic nmi_clr_req;
    } wr_cmd_t;

endpackage

// File: rtl/icsr_bus_decode.sv
// Module: icsr_bus_decode
// Decodes one register-port access into a read enable, an offset hit,
// a bank one-hot and a write command. Purely combinational. Assumes a
// single access per cycle with no wait states.
module icsr_bus_decode
    import icsr_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD04
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_secure,
    output logic              rd_en,
    output logic              hit,
    output logic [NBANK-1:0]  bank_sel,
    output wr_cmd_t           cmd
);

    logic wr_hit;
    logic wdata_unused;

    // Bits with no write meaning are folded away here
    assign wdata_unused = ^{req_wdata[29], req_wdata[24:0]};

    // Access classification
    always_comb begin
        hit    = req_valid && (req_addr == REG_OFFSET);
        rd_en  = req_valid && !req_write;
        wr_hit = hit && req_write;
    end

    // One-hot of the bank chosen by the access's secure attribute
    always_comb begin
        bank_sel             = '0;
        bank_sel[req_secure] = 1'b1;
    end

    // Write command fields, each qualified by a write to this register
    always_comb begin
        cmd.tick_set    = wr_hit && req_wdata[BIT_TICK_SET];
        cmd.tick_clr    = wr_hit && req_wdata[BIT_TICK_CLR];
        cmd.sv_set      = wr_hit && req_wdata[BIT_SV_SET];
        cmd.sv_clr      = wr_hit && req_wdata[BIT_SV_CLR];
        cmd.nmi_set     = wr_hit && req_wdata[BIT_NMI_SET];
        cmd.nmi_clr_req = wr_hit && !req_wdata[BIT_NMI_SET]
                                 && req_wdata[BIT_NMI_CLR];
    end

endmodule

// File: rtl/icsr_pend_bank.sv
// Module: icsr_pend_bank
// Holds the timer and service pending flags of one security bank.
// Assumes all set and clear requests are single-cycle pulses. A set
// beats a clear of the same flag in the same cycle.
module icsr_pend_bank (
    input  logic clk,
    input  logic rst_n,
    input  logic set_tick,
    input  logic clr_tick,
    input  logic set_sv,
    input  logic clr_sv,
    output logic tick_pend,
    output logic sv_pend
);

    // Flag update with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_pend <= 1'b0;
            sv_pend   <= 1'b0;
        end else begin
            tick_pend <= set_tick | (tick_pend & ~clr_tick);
            sv_pend   <= set_sv   | (sv_pend   & ~clr_sv);
        end
    end

endmodule

// File: rtl/icsr_nmi_ctrl.sv
// Module: icsr_nmi_ctrl
// Holds the single NMI pending flag. Software control is gated by the
// non-secure enable; the pend-clear path exists only when NEW_ARCH is 1.
// Assumes requests are single-cycle pulses; any set beats any clear.
module icsr_nmi_ctrl #(
    parameter bit NEW_ARCH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ns_en,
    input  logic wr_set,
    input  logic wr_clr_req,
    input  logic evt,
    input  logic ack,
    output logic nmi_pend,
    output logic nmi_vis
);

    logic sw_set;
    logic sw_clr;

    // Software set is honoured only while the enable is on
    assign sw_set = wr_set && ns_en;

    // Software clear exists only in the newer mode
    generate
        if (NEW_ARCH) begin : g_clr_path
            assign sw_clr = wr_clr_req && ns_en;
        end else begin : g_no_clr_path
            logic clr_unused;
            assign clr_unused = wr_clr_req;
            assign sw_clr     = 1'b0;
        end
    endgenerate

    // Pending flag with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_pend <= 1'b0;
        end else begin
            nmi_pend <= (evt | sw_set) | (nmi_pend & ~(ack | sw_clr));
        end
    end

    // Flag as reported to software
    assign nmi_vis = nmi_pend && ns_en;

endmodule

// File: rtl/icsr_read_mux.sv
// Module: icsr_read_mux
// Assembles the read word from the banked flags and the side inputs,
// and registers it, giving one cycle of read latency. Returns zero for
// offsets other than the register. Assumes VEC_W is at most FIELD_W.
module icsr_read_mux
    import icsr_pkg::*;
#(
    parameter int VEC_W   = 9,
    parameter int DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               hit,
    input  logic               bank,
    input  logic [NBANK-1:0]   tick_pend,
    input  logic [NBANK-1:0]   sv_pend,
    input  logic               nmi_vis,
    input  logic [VEC_W-1:0]   active_vec,
    input  logic [VEC_W-1:0]   pend_vec,
    input  logic [DEPTH_W-1:0] active_depth,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data
);

    logic [DATA_W-1:0] word;
    logic              ret_base;

    // Return goes to base level when at most one exception is active
    assign ret_base = (active_depth <= DEPTH_W'(1));

    // Word assembly; unlisted bits stay zero
    always_comb begin
        word                          = '0;
        word[BIT_NMI_SET]             = nmi_vis;
        word[BIT_SV_SET]              = sv_pend[bank];
        word[BIT_TICK_SET]            = tick_pend[bank];
        word[PVEC_LSB +: FIELD_W]     = FIELD_W'(pend_vec);
        word[BIT_RTB]                 = ret_base;
        word[AVEC_LSB +: FIELD_W]     = FIELD_W'(active_vec);
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= (rd_en && hit) ? word : '0;
        end
    end

endmodule

// File: rtl/icsr_banked.sv
// Module: icsr_banked (top)
// Interrupt control and state register with secure and non-secure banks
// of timer and service pending flags plus a gated NMI pending flag.
// Assumes one access per cycle, synchronous active-low reset, and that
// vector numbers and nesting depth come from the surrounding controller.
module icsr_banked
    import icsr_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD04,
    parameter int                VEC_W      = 9,
    parameter int                DEPTH_W    = 4,
    parameter bit                NEW_ARCH   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    input  logic               req_secure,
    input  logic               nmi_ns_en,
    input  logic [VEC_W-1:0]   active_vec,
    input  logic [VEC_W-1:0]   pend_vec,
    input  logic [DEPTH_W-1:0] active_depth,
    input  logic [1:0]         tick_evt,
    input  logic [1:0]         tick_ack,
    input  logic [1:0]         sv_ack,
    input  logic               nmi_evt,
    input  logic               nmi_ack,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    output logic [1:0]         tick_pend,
    output logic [1:0]         sv_pend,
    output logic               nmi_pend
);

    logic             rd_en;
    logic             hit;
    logic [NBANK-1:0] bank_sel;
    wr_cmd_t          cmd;
    logic             nmi_vis;

    // Access decode
    icsr_bus_decode #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) decode_i (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_secure (req_secure),
        .rd_en      (rd_en),
        .hit        (hit),
        .bank_sel   (bank_sel),
        .cmd        (cmd)
    );

    // One pending bank per security state
    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            icsr_pend_bank bank_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_tick  (tick_evt[b] | (cmd.tick_set & bank_sel[b])),
                .clr_tick  (tick_ack[b] | (cmd.tick_clr & bank_sel[b])),
                .set_sv    (cmd.sv_set & bank_sel[b]),
                .clr_sv    (sv_ack[b]  | (cmd.sv_clr  & bank_sel[b])),
                .tick_pend (tick_pend[b]),
                .sv_pend   (sv_pend[b])
            );
        end
    endgenerate

    // NMI pending state
    icsr_nmi_ctrl #(
        .NEW_ARCH (NEW_ARCH)
    ) nmi_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ns_en      (nmi_ns_en),
        .wr_set     (cmd.nmi_set),
        .wr_clr_req (cmd.nmi_clr_req),
        .evt        (nmi_evt),
        .ack        (nmi_ack),
        .nmi_pend   (nmi_pend),
        .nmi_vis    (nmi_vis)
    );

    // Read word and response register
    icsr_read_mux #(
        .VEC_W   (VEC_W),
        .DEPTH_W (DEPTH_W)
    ) rmux_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .hit          (hit),
        .bank         (req_secure),
        .tick_pend    (tick_pend),
        .sv_pend      (sv_pend),
        .nmi_vis      (nmi_vis),
        .active_vec   (active_vec),
        .pend_vec     (pend_vec),
        .active_depth (active_depth),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data)
    );

endmodule

// File: rtl/icsr_banked_chk.sv
// Module: icsr_banked_chk
// Temporal checks on the ports of icsr_banked, attached by bind below.
// Assumes the same offset parameter as the checked instance.
module icsr_banked_chk #(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD04
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        wr_tick_bits,
    input logic              req_secure,
    input logic              nmi_ns_en,
    input logic [1:0]        tick_evt,
    input logic              nmi_evt,
    input logic              nmi_ack,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic [1:0]        tick_pend,
    input logic [1:0]        sv_pend,
    input logic              nmi_pend
);

    logic wr_hit;
    assign wr_hit = req_valid && req_write && (req_addr == REG_OFFSET);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (tick_pend == 2'b00 && sv_pend == 2'b00 && !nmi_pend && !rd_valid));

    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    a_r4_bank_select: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_addr == REG_OFFSET)) |->
        (rd_data[26] == ($past(req_secure) ? $past(tick_pend[1]) : $past(tick_pend[0]))));

    a_r5_ns_tick_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_tick_bits[1] && !req_secure) |=> tick_pend[0]);

    a_r6_ns_tick_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_tick_bits[0] && !wr_tick_bits[1] && !req_secure && !tick_evt[0])
        |=> !tick_pend[0]);

    a_r7_evt_pends: assert property (@(posedge clk) disable iff (!rst_n)
        tick_evt[1] |=> tick_pend[1]);

    a_r8_nmi_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_data[31]) |-> ($past(nmi_ns_en) && $past(nmi_pend)));

    a_r9_nmi_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !nmi_ns_en && !nmi_evt && !nmi_ack) |=> (nmi_pend == $past(nmi_pend)));

    a_r11_other_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_addr != REG_OFFSET)) |-> (rd_data == 32'h0));

    a_r12_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[30:29] == 2'b00 && !rd_data[27] &&
                      rd_data[25:21] == 5'b0 && rd_data[10:9] == 2'b00));

    a_r13_nmi_evt: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_evt |=> nmi_pend);

endmodule

bind icsr_banked icsr_banked_chk #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .wr_tick_bits (req_wdata[26:25]),
    .req_secure   (req_secure),
    .nmi_ns_en    (nmi_ns_en),
    .tick_evt     (tick_evt),
    .nmi_evt      (nmi_evt),
    .nmi_ack      (nmi_ack),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .tick_pend    (tick_pend),
    .sv_pend      (sv_pend),
    .nmi_pend     (nmi_pend)
);

// File: tb/icsr_banked_tb.sv
// Bench: drives a new-mode and a legacy-mode instance with the same
// stimulus and compares both against a reference state every cycle.
module icsr_banked_tb_top;

    localparam logic [11:0] OFF = 12'hD04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        nmi_ns_en = 1'b0;
    logic [8:0]  active_vec = '0, pend_vec = '0;
    logic [3:0]  active_depth = '0;
    logic [1:0]  tick_evt = '0, tick_ack = '0, sv_ack = '0;
    logic        nmi_evt = 1'b0, nmi_ack = 1'b0;

    // index 1 = new mode (dut_i), index 0 = legacy mode
    logic        rd_valid_o  [2];
    logic [31:0] rd_data_o   [2];
    logic [1:0]  tick_pend_o [2];
    logic [1:0]  sv_pend_o   [2];
    logic        nmi_pend_o  [2];

    logic [1:0]  m_tick [2];
    logic [1:0]  m_sv   [2];
    logic        m_nmi  [2];
    logic [31:0] e_rd   [2];
    logic        e_rv;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    icsr_banked #(.NEW_ARCH(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
        .nmi_ns_en(nmi_ns_en), .active_vec(active_vec), .pend_vec(pend_vec),
        .active_depth(active_depth), .tick_evt(tick_evt), .tick_ack(tick_ack),
        .sv_ack(sv_ack), .nmi_evt(nmi_evt), .nmi_ack(nmi_ack),
        .rd_valid(rd_valid_o[1]), .rd_data(rd_data_o[1]),
        .tick_pend(tick_pend_o[1]), .sv_pend(sv_pend_o[1]), .nmi_pend(nmi_pend_o[1]));

    icsr_banked #(.NEW_ARCH(1'b0)) dut_legacy_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
        .nmi_ns_en(nmi_ns_en), .active_vec(active_vec), .pend_vec(pend_vec),
        .active_depth(active_depth), .tick_evt(tick_evt), .tick_ack(tick_ack),
        .sv_ack(sv_ack), .nmi_evt(nmi_evt), .nmi_ack(nmi_ack),
        .rd_valid(rd_valid_o[0]), .rd_data(rd_data_o[0]),
        .tick_pend(tick_pend_o[0]), .sv_pend(sv_pend_o[0]), .nmi_pend(nmi_pend_o[0]));

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Read word expected from the requirements for the current inputs
    function automatic logic [31:0] exp_word(input int a);
        logic [31:0] w = '0;
        w[31]    = m_nmi[a] & nmi_ns_en;
        w[28]    = m_sv[a][req_secure];
        w[26]    = m_tick[a][req_secure];
        w[20:12] = pend_vec;
        w[11]    = (active_depth <= 4'd1);
        w[8:0]   = active_vec;
        return w;
    endfunction

    // One clock: predict, step the edge, compare at the falling edge
    task automatic step(input string tag);
        logic        hit = req_valid && (req_addr == OFF);
        logic        wr  = hit && req_write;
        logic [1:0]  bs  = req_secure ? 2'b10 : 2'b01;
        logic [1:0]  nt [2];
        logic [1:0]  ns [2];
        logic        nn [2];
        logic [31:0] rd [2];
        logic        rv;
        for (int a = 0; a < 2; a++) begin
            logic [1:0] st = tick_evt | ((wr && req_wdata[26]) ? bs : 2'b00);
            logic [1:0] ct = tick_ack | ((wr && req_wdata[25]) ? bs : 2'b00);
            logic [1:0] ss = (wr && req_wdata[28]) ? bs : 2'b00;
            logic [1:0] cs = sv_ack   | ((wr && req_wdata[27]) ? bs : 2'b00);
            logic sn = nmi_evt | (wr && nmi_ns_en && req_wdata[31]);
            logic cn = nmi_ack | (wr && nmi_ns_en && !req_wdata[31] && req_wdata[30] && (a == 1));
            nt[a] = st | (m_tick[a] & ~ct);
            ns[a] = ss | (m_sv[a] & ~cs);
            nn[a] = sn | (m_nmi[a] & ~cn);
            rd[a] = (req_valid && !req_write && hit) ? exp_word(a) : 32'h0;
        end
        rv = req_valid && !req_write;
        if (!rst_n) begin
            for (int a = 0; a < 2; a++) begin
                nt[a] = '0; ns[a] = '0; nn[a] = 1'b0; rd[a] = '0;
            end
            rv = 1'b0;
        end
        @(posedge clk);
        for (int a = 0; a < 2; a++) begin
            m_tick[a] = nt[a]; m_sv[a] = ns[a]; m_nmi[a] = nn[a]; e_rd[a] = rd[a];
        end
        e_rv = rv;
        @(negedge clk);
        for (int a = 0; a < 2; a++) begin
            string sfx = (a == 1) ? " new" : " legacy";
            chk(tag, {"rd_valid", sfx}, 32'(rd_valid_o[a]), 32'(e_rv));
            chk(tag, {"rd_data", sfx},  rd_data_o[a], e_rd[a]);
            chk(tag, {"tick_pend", sfx}, 32'(tick_pend_o[a]), 32'(m_tick[a]));
            chk(tag, {"sv_pend", sfx},   32'(sv_pend_o[a]),   32'(m_sv[a]));
            chk(tag, {"nmi_pend", sfx},  32'(nmi_pend_o[a]),  32'(m_nmi[a]));
        end
    endtask

    task automatic idle();
        req_valid = 1'b0; req_write = 1'b0;
        tick_evt = '0; tick_ack = '0; sv_ack = '0; nmi_evt = 1'b0; nmi_ack = 1'b0;
    endtask

    task automatic do_write(input logic [11:0] addr, input logic [31:0] data,
                            input logic sec, input string tag);
        idle();
        req_valid = 1'b1; req_write = 1'b1; req_addr = addr;
        req_wdata = data; req_secure = sec;
        step(tag);
        idle();
    endtask

    task automatic do_read(input logic [11:0] addr, input logic sec, input string tag);
        idle();
        req_valid = 1'b1; req_addr = addr; req_secure = sec;
        step(tag);
        idle();
    endtask

    initial begin
        for (int a = 0; a < 2; a++) begin
            m_tick[a] = '0; m_sv[a] = '0; m_nmi[a] = 1'b0; e_rd[a] = '0;
        end
        e_rv = 1'b0;
        @(negedge clk);
        // R1: reset state, with activity requested during reset
        tick_evt = 2'b11; nmi_evt = 1'b1;
        step("R1");
        idle();
        step("R1");
        rst_n = 1'b1;

        // R2, R3: vector fields and return-to-base over depths
        for (int d = 0; d < 6; d++) begin
            for (int k = 0; k < 8; k++) begin
                active_depth = 4'(d);
                active_vec   = 9'(k * 61 + d);
                pend_vec     = 9'(511 - k * 37);
                do_read(OFF, k[0], (d < 3) ? "R3" : "R2");
            end
        end
        step("R2");

        // R4, R5, R6, R8, R9: exhaustive write-control sweep
        for (int sec = 0; sec < 2; sec++) begin
            for (int en = 0; en < 2; en++) begin
                for (int st = 0; st < 2; st++) begin
                    for (int c = 0; c < 64; c++) begin
                        logic [31:0] w = '0;
                        string tg;
                        nmi_ns_en = 1'b1;
                        if (st == 1) begin
                            idle(); tick_evt = 2'b11; nmi_evt = 1'b1;
                            step("R7");
                            do_write(OFF, 32'h1000_0000, 1'b0, "R5");
                            do_write(OFF, 32'h1000_0000, 1'b1, "R5");
                        end else begin
                            idle(); tick_ack = 2'b11; sv_ack = 2'b11; nmi_ack = 1'b1;
                            step("R13");
                            idle();
                        end
                        nmi_ns_en = en[0];
                        w[25] = c[0]; w[26] = c[1]; w[27] = c[2];
                        w[28] = c[3]; w[30] = c[4]; w[31] = c[5];
                        tg = (c[5] | c[4]) ? "R9" : ((c[0] | c[2]) ? "R6" : "R5");
                        do_write(OFF, w, sec[0], tg);
                        do_read(OFF, sec[0], "R4");
                        do_read(OFF, !sec[0], "R8");
                    end
                end
            end
        end

        // R10: pend-clear bit ignored in legacy mode
        nmi_ns_en = 1'b1;
        idle(); nmi_evt = 1'b1; step("R13"); idle();
        do_write(OFF, 32'h4000_0000, 1'b0, "R10");
        chk("R10", "legacy nmi after clear bit", 32'(nmi_pend_o[0]), 32'd1);
        chk("R10", "new nmi after clear bit",    32'(nmi_pend_o[1]), 32'd0);
        do_write(OFF, 32'hC000_0000, 1'b1, "R9");
        chk("R9", "set with clear bit", 32'(nmi_pend_o[1]), 32'd1);

        // R7, R13: hardware set/clear priority sweep
        for (int c = 0; c < 64; c++) begin
            idle();
            tick_evt = c[1:0]; tick_ack = c[3:2];
            nmi_evt = c[4]; nmi_ack = c[5];
            step((c[5] | c[4]) ? "R13" : "R7");
        end
        for (int s = 0; s < 2; s++) begin
            idle(); req_valid = 1'b1; req_write = 1'b1; req_addr = OFF;
            req_wdata = 32'h1200_0000; req_secure = s[0];
            sv_ack = 2'b11; tick_ack = 2'b11;
            step("R7");
            idle();
            do_read(OFF, s[0], "R7");
        end

        // R11: other offsets, R12: reserved bits with all flags set
        do_write(12'hD00, 32'hFFFF_FFFF, 1'b0, "R11");
        do_write(12'hD08, 32'hFFFF_FFFF, 1'b1, "R11");
        do_write(12'h504, 32'hFFFF_FFFF, 1'b0, "R11");
        do_read(12'hD00, 1'b0, "R11");
        do_read(12'hD05, 1'b1, "R11");
        do_write(OFF, 32'hFFFF_FFFF, 1'b0, "R12");
        do_write(OFF, 32'hFFFF_FFFF, 1'b1, "R12");
        active_depth = 4'd2; active_vec = 9'h1FF; pend_vec = 9'h1FF;
        do_read(OFF, 1'b0, "R12");
        do_read(OFF, 1'b1, "R12");
        step("R2");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog: actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule